// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-word SPI master that sits behind a 32-bit register port. Software selects a peripheral through a control register, picks an 8-bit or 16-bit word size in a configuration register, and starts a transfer by writing the transmit-data register. The engine then shifts that word out on MOSI while capturing MISO. Only clock mode 0 is used: SCK idles low, MISO is sampled on the rising SCK edge, and MOSI changes on the falling edge.

When the last bit has been exchanged, the engine raises a ready flag and latches the received word into the receive-data register. Software can poll the flag in the control register. The same flag appears as bit 0 of an interrupt-cause register, and it drives an interrupt line when the matching mask bit is set. The SCK rate comes from a separate divider block. A parameter sets how many system clocks make up each SCK half-period.

Top module: `spi_word_master`

## Requirements
- R1: After reset, every chip-select line is high, SCK is low, the ready flag and the interrupt are low, and the control, configuration and mask registers read as zero.
- R2: The register word offsets are fixed as follows: control at 0x00, configuration at 0x04, transmit data at 0x08, receive data at 0x0C, interrupt cause at 0x10 and interrupt mask at 0x14. A read of the transmit-data offset returns zero.
- R3: Chip-select lines are active low. Line i is low only when control bit 0 (the enable) is 1 and control bits 4:2 equal i. At most one line is low at any time.
- R4: A write to the transmit-data register while idle starts exactly one transfer. Configuration bit 5 sets the word size at the time of the write: 1 selects 16 bits and 0 selects 8 bits. The transfer produces exactly that many rising SCK edges.
- R5: Words go out most-significant bit first, in mode 0. SCK is low whenever no transfer runs. In 16-bit mode, write-data bit 15 is sent first. In 8-bit mode, write-data bit 7 is sent first.
- R6: When a transfer ends, the ready flag (control bit 1) is set. The receive-data register then holds the captured word. In 8-bit mode the captured byte is in bits 7:0 and bits 15:8 read as zero. The first bit received is the most-significant bit of the word.
- R7: The ready flag clears when a new transfer is started by a transmit-data write, and also when the receive-data register is read.
- R8: A write to the transmit-data register while a transfer is in progress is ignored. It does not restart, extend or change the transfer that is running.
- R9: Interrupt-cause bit 0 mirrors the ready flag. The interrupt output is a register: it is high one cycle after both the ready flag and mask bit 0 are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a read of receive data clears the ready flag) |
| regAddr | input | ADDR_W | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| sck | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | NUM_CS | Active-low chip selects |
| irq | output | 1 | Masked ready interrupt |

## Verification
The main function is driven from a table of transfers. The table mixes 8-bit and 16-bit sizes and uses transmit and slave words with only the top bit set, only the bottom bit set, and mixed patterns. These patterns separate a correct MSB-first order from a reversed or truncated shift. They also reveal a wrong word-size choice, because the count of SCK edges and the zero upper byte of an 8-bit receive both change. A bus-functional slave in the bench returns a known word. This shows whether sampling happens on the correct SCK edge, since an off-by-one sample shifts the received word. Directed tests cover chip-select decoding, clearing of the ready flag, the interrupt with mask on and off, and a second write made during a transfer.

// File: rtl/spi_word_master_pkg.sv
package spi_word_master_pkg;
  // word index of each register (byte address bits 4:2)
  localparam logic [2:0] IDX_CTRL  = 3'd0;
  localparam logic [2:0] IDX_CFG   = 3'd1;
  localparam logic [2:0] IDX_TX    = 3'd2;
  localparam logic [2:0] IDX_RX    = 3'd3;
  localparam logic [2:0] IDX_CAUSE = 3'd4;
  localparam logic [2:0] IDX_MASK  = 3'd5;

  localparam int WORD_W = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture tx word, begin transfer
    logic sample;  // rising SCK: take miso
    logic shift;   // falling SCK: advance mosi
    logic finish;  // last falling edge: publish rx word
  } spiStrobe_t;
endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_word_master_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txWr,
  input  logic       wide,
  input  logic       tick,
  output spiStrobe_t strb,
  output logic       busy,
  output logic       sck
);
  logic [4:0] bitsLeft;

  always_comb begin
    strb = '0;
    if (txWr && !busy) strb.load = 1'b1;
    if (busy && tick) begin
      if (!sck) strb.sample = 1'b1;
      else begin
        strb.shift = 1'b1;
        if (bitsLeft == 5'd1) strb.finish = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      sck      <= 1'b0;
      bitsLeft <= '0;
    end else if (strb.load) begin
      busy     <= 1'b1;
      sck      <= 1'b0;
      bitsLeft <= wide ? 5'd16 : 5'd8;
    end else if (strb.sample) begin
      sck <= 1'b1;
    end else if (strb.shift) begin
      sck      <= 1'b0;
      bitsLeft <= bitsLeft - 1'b1;
      if (strb.finish) busy <= 1'b0;
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck); // R5
  AST_FINISH_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (!busy && !sck)); // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txWr && !strb.finish) |=> (busy && $stable(bitsLeft) || busy && bitsLeft == $past(bitsLeft) - 5'd1)); // R8
endmodule

// File: rtl/spi_datapath.sv
module spi_datapath
  import spi_word_master_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] wdata,
  output logic [31:0]       regRdata,
  input  spiStrobe_t        strb,
  input  logic              miso,
  output logic              mosi,
  output logic              wide,
  output logic              txWr,
  output logic [NUM_CS-1:0] csN,
  output logic              irq
);
  logic [2:0]        wordIdx;
  logic              csEn, ready, maskBit, rxRead;
  logic [2:0]        csIdx;
  logic [WORD_W-1:0] txSh, rxSh, rxData;

  assign wordIdx = regAddr[4:2];
  assign txWr    = regWrEn && wordIdx == IDX_TX;
  assign rxRead  = regRdEn && wordIdx == IDX_RX;
  assign mosi    = txSh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csEn <= 1'b0; csIdx <= '0; wide <= 1'b0; maskBit <= 1'b0;
    end else if (regWrEn) begin
      case (wordIdx)
        IDX_CTRL: begin csEn <= wdata[0]; csIdx <= wdata[4:2]; end
        IDX_CFG:  wide <= wdata[5];
        IDX_MASK: maskBit <= wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh <= '0; rxSh <= '0; rxData <= '0; ready <= 1'b0; irq <= 1'b0;
    end else begin
      irq <= ready && maskBit;
      if (strb.load) txSh <= wide ? wdata : {wdata[7:0], 8'h00};
      else if (strb.shift) txSh <= {txSh[WORD_W-2:0], 1'b0};
      if (strb.load) rxSh <= '0;
      else if (strb.sample) rxSh <= {rxSh[WORD_W-2:0], miso};
      if (strb.finish) begin
        rxData <= wide ? rxSh : {8'h00, rxSh[7:0]};
        ready  <= 1'b1;
      end else if (strb.load || rxRead) begin
        ready <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csN[i] = !(csEn && csIdx == 3'(i));
  end

  always_comb begin
    regRdata = '0;
    case (wordIdx)
      IDX_CTRL:  regRdata = {27'd0, csIdx, ready, csEn};
      IDX_CFG:   regRdata = {26'd0, wide, 5'd0};
      IDX_RX:    regRdata = {16'd0, rxData};
      IDX_CAUSE: regRdata = {31'd0, ready};
      IDX_MASK:  regRdata = {31'd0, maskBit};
      default:   regRdata = '0;
    endcase
  end

  AST_READY_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !ready); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(maskBit) && $past(ready))); // R9
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_master_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int NUM_CS   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN,
  output logic              irq
);
  spiStrobe_t strb;
  logic busy, tick, wide, txWr;
  logic unusedBits;
  assign unusedBits = ^{regWdata[31:WORD_W], regAddr[1:0]};

  spi_sck_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rstN(rstN), .run(busy), .tick(tick));

  spi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txWr(txWr), .wide(wide), .tick(tick),
    .strb(strb), .busy(busy), .sck(sck));

  spi_datapath #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .wdata(regWdata[WORD_W-1:0]), .regRdata(regRdata),
    .strb(strb), .miso(miso), .mosi(mosi), .wide(wide), .txWr(txWr),
    .csN(csN), .irq(irq));

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN)); // R3
endmodule

// File: tb/spi_word_master_bench.sv
module spi_word_master_bench;
  logic clk = 0, rstN = 0, regWrEn = 0, regRdEn = 0, miso;
  logic [4:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic sck, mosi, irq;
  logic [7:0] csN;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  spi_word_master u_spi_word_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .sck(sck), .mosi(mosi), .miso(miso), .csN(csN), .irq(irq));

  // bench-side slave
  logic [15:0] slaveSh = '0, mcap = '0;
  int rises = 0;
  assign miso = slaveSh[15];
  always @(negedge sck) slaveSh <= slaveSh << 1;
  always @(posedge sck) begin mcap <= {mcap[14:0], mosi}; rises <= rises + 1; end

  // {wide, tx word, slave word}
  localparam logic [32:0] VEC [4] = '{
    {1'b0, 16'h00A5, 16'h003C},
    {1'b1, 16'h1234, 16'hABCD},
    {1'b0, 16'hFF81, 16'h5A7F},
    {1'b1, 16'h8000, 16'h0001}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1; regAddr = a; #1 d = regRdata;
    @(negedge clk); regRdEn = 0;
  endtask

  task automatic waitReady();
    logic [31:0] v;
    for (int i = 0; i < 500; i++) begin
      rd(5'h00, v);
      if (v[1]) return;
    end
    check("R6 ready timeout", 0, 1);
  endtask

  task automatic prepSlave(logic w, logic [15:0] s);
    rises = 0; mcap = '0;
    slaveSh = w ? s : {s[7:0], 8'h00};
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    @(negedge clk);
    check("R1 csN", csN, 8'hFF);
    check("R1 sck", sck, 0);
    check("R1 irq", irq, 0);
    rd(5'h00, v); check("R1 ctrl", v, 0);
    rd(5'h04, v); check("R1 cfg", v, 0);
    rd(5'h14, v); check("R1 mask", v, 0);

    // R3 chip select decode
    wr(5'h00, 32'h14);  // idx 5, enable 0
    @(negedge clk); check("R3 disabled", csN, 8'hFF);
    wr(5'h00, 32'h15);  // idx 5, enable 1
    @(negedge clk); check("R3 idx5", csN, 8'hDF);
    rd(5'h00, v); check("R2 ctrl readback", v, 32'h15);
    wr(5'h00, 32'h01);
    @(negedge clk); check("R3 idx0", csN, 8'hFE);

    // table walk: R4 R5 R6
    foreach (VEC[k]) begin
      logic w; logic [15:0] tx, sl;
      {w, tx, sl} = VEC[k];
      wr(5'h04, w ? 32'h20 : 32'h0);
      rd(5'h04, v); check("R2 cfg readback", v, w ? 32'h20 : 32'h0);
      prepSlave(w, sl);
      wr(5'h08, {16'hDEAD, tx});
      waitReady();
      check("R4 sck edges", rises, w ? 16 : 8);
      check("R5 mosi order", w ? mcap : {8'h00, mcap[7:0]}, w ? tx : {8'h00, tx[7:0]});
      check("R5 sck idle", sck, 0);
      rd(5'h0C, v); check("R6 rx word", v, w ? sl : {8'h00, sl[7:0]});
      rd(5'h00, v); check("R7 ready cleared by rx read", v[1], 0);
    end
    rd(5'h08, v); check("R2 tx reads zero", v, 0);

    // R9 interrupt mask off then on
    wr(5'h04, 32'h0);
    prepSlave(0, 16'h0096);
    wr(5'h08, 32'h69);
    waitReady();
    rd(5'h10, v); check("R9 cause", v, 1);
    @(negedge clk); check("R9 irq masked", irq, 0);
    wr(5'h14, 32'h1);
    @(negedge clk); check("R9 irq on", irq, 1);

    // R7 tx write clears ready
    prepSlave(0, 16'h0011);
    wr(5'h08, 32'h22);
    rd(5'h00, v); check("R7 ready cleared by tx write", v[1], 0);
    check("R9 irq drops", irq, 0);
    waitReady();
    rd(5'h0C, v); check("R6 rx after restart", v, 32'h11);
    wr(5'h14, 32'h0);

    // R8 write during busy ignored
    prepSlave(0, 16'h00C3);
    wr(5'h08, 32'h3C);
    repeat (3) @(negedge clk);
    wr(5'h08, 32'hFF);
    waitReady();
    repeat (40) @(negedge clk);
    check("R8 single transfer edges", rises, 8);
    check("R8 mosi unchanged", {8'h00, mcap[7:0]}, 32'h3C);
    rd(5'h0C, v); check("R8 rx", v, 32'hC3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule